// File: doc/BRIEF.md
# I2C Master Byte-Count Transfer Sequencer

This block is the control core of an I2C master. Software describes a transfer with a 7-bit target address, a direction, a byte count, a reload flag and an auto-end flag. It writes them together with a start request. The sequencer then drives a separate bit-level bus engine one command at a time: START (or repeated START), the address byte, data bytes out of a one-byte transmit register or into a one-byte receive register, and STOP. The engine handles SCL/SDA timing and reports completion, the acknowledge it received, arbitration loss and bus errors.

The count covers one segment of 1 to 255 bytes. When it runs out, the block does one of three things. With reload set, it pauses the bus and raises a reload-complete flag until software writes a new count. With auto-end set, it issues STOP by itself. Otherwise it raises transfer-complete and holds the bus until software asks for STOP or for a new START, which goes out as a repeated START. NACK, arbitration-lost and bus-error flags are sticky, and each is cleared through its own bit of a clear input. A single interrupt output covers the two completion flags.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After a start request the engine receives START and then a WRITE of the address byte `{cfgAddr, cfgRead}`. Bit 0 of that byte is the direction: 0 means write, 1 means read. Engine command codes are 0 START, 1 WRITE, 2 READ, 3 STOP.
- R2: In write direction, each data byte sent is the byte most recently loaded into the transmit register. No data WRITE is issued while that register is empty; `txReq` is high while a byte is awaited. The register reads empty again once its byte has been handed to the engine.
- R3: When the count reaches zero with reload clear and auto-end set, STOP follows the last byte and `xferDone` stays low.
- R4: When the count reaches zero with reload and auto-end both clear, `xferDone` rises and the bus stays held (`busBusy` high, no STOP). A configuration write with the stop bit set then issues STOP. A configuration write with the start bit set issues a repeated START, with no STOP before it.
- R5: When the count reaches zero with reload set, `xferReload` rises and the transfer pauses. A configuration write loads the new count, clears `xferReload` and resumes with no START and no address byte.
- R6: `xferDone` and `xferReload` ignore `clrFlags`. Only a configuration write clears them.
- R7: `irq` is high exactly when `irqEn` is high and `xferDone` or `xferReload` is set.
- R8: `startPend` rises with a start request and falls when the address phase ends. From idle, START is not issued while `lineBusy` is high.
- R9: In read direction, each byte is given ACK (`engAckOut`=1), except the last byte of a segment with reload clear, which gets NACK. Each received byte appears on `rxData` with `rxFull` high. No READ is issued while `rxFull` is high, and `rxRd` clears `rxFull`.
- R10: A NACK received for the address or a data byte sets `nackFlag` (`clrFlags` bit 0 clears it). With auto-end set, STOP follows. With auto-end clear, the bus is held until a stop request.
- R11: Arbitration loss sets `arloFlag` (`clrFlags` bit 1 clears it). The block returns to idle at once, clears `startPend` and issues no STOP.
- R12: A bus-error report from the engine sets `berrFlag`, and `clrFlags` bit 2 clears it.
- R13: A pulse on `txFlush` makes the transmit register read empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWr | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Target address |
| cfgRead | input | 1 | Direction, 1 = read |
| cfgCount | input | CNT_W | Segment byte count |
| cfgReload | input | 1 | Pause for a new count at the end of the segment |
| cfgAutoEnd | input | 1 | Issue STOP by itself at the end |
| cfgStart | input | 1 | Start / repeated-start request |
| cfgStop | input | 1 | Stop request |
| txWr | input | 1 | Load the transmit register |
| txData | input | 8 | Transmit byte |
| txFlush | input | 1 | Force the transmit register empty |
| rxRd | input | 1 | Receive byte taken |
| clrFlags | input | 3 | Clear bits: 0 NACK, 1 arbitration, 2 bus error |
| irqEn | input | 1 | Completion interrupt enable |
| startPend | output | 1 | Start request in progress |
| busBusy | output | 1 | Bus in use |
| txEmpty | output | 1 | Transmit register empty |
| txReq | output | 1 | Transmit byte requested |
| rxFull | output | 1 | Receive byte available |
| rxData | output | 8 | Received byte |
| xferDone | output | 1 | Transfer complete, bus held |
| xferReload | output | 1 | Segment complete, waiting for a count |
| nackFlag | output | 1 | NACK received |
| arloFlag | output | 1 | Arbitration lost |
| berrFlag | output | 1 | Bus error |
| irq | output | 1 | Completion interrupt |
| engGo | output | 1 | Engine command strobe |
| engCmd | output | 2 | Engine command code |
| engTxByte | output | 8 | Byte for a WRITE command |
| engAckOut | output | 1 | Acknowledge to drive after a READ |
| engDone | input | 1 | Engine command finished |
| engAckIn | input | 1 | Acknowledge received, 1 = ACK |
| engRxByte | input | 8 | Byte from a READ |
| engArlo | input | 1 | Arbitration lost |
| engBerr | input | 1 | Bus error |
| lineBusy | input | 1 | Bus busy as seen on the lines |

## Verification
The assertions rely on the engine following a strict handshake. It accepts at most one command at a time. It never reports completion in the same cycle as the command strobe. After arbitration loss it abandons the command without reporting completion. The bench's engine model enforces this with a fixed latency and a single-command timer. The bench sends configuration writes only while the block is idle, holding the bus or paused. It pulses `rxRd` only while `rxFull` is high and never together with an incoming byte, and `txWr` only while `txEmpty` is high.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;

  localparam int NUM_ERR = 3;  // bit 0 nack, bit 1 arbitration, bit 2 bus error

  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_WRITE = 2'd1,
    ENG_READ  = 2'd2,
    ENG_STOP  = 2'd3
  } engCmdT;

  typedef struct packed {
    logic loadAll;
    logic loadCnt;
    logic decCnt;
    logic txPop;
    logic rxPush;
    logic setTc;
    logic setTcr;
    logic clrDone;
    logic setNack;
    logic startSet;
    logic startClr;
  } seqStrbT;

endpackage

// File: rtl/i2c_xfer_ctrl.sv
module i2c_xfer_ctrl
  import i2c_xfer_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgWr,
  input  logic    cfgStart,
  input  logic    cfgStop,
  input  logic    engDone,
  input  logic    engAckIn,
  input  logic    engArlo,
  input  logic    lineBusy,
  input  logic    cntZero,
  input  logic    cntOne,
  input  logic    txFull,
  input  logic    rxFull,
  input  logic    readDir,
  input  logic    reload,
  input  logic    autoEnd,
  input  logic    startPend,
  output seqStrbT strb,
  output logic    engGo,
  output engCmdT  engCmd,
  output logic    engAckOut,
  output logic    selAddr,
  output logic    wantTx,
  output logic    active
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CHECK, S_WR, S_RD, S_PAUSE, S_HOLD, S_STOP
  } stateT;

  stateT stateQ, stateD;
  logic  issuedQ;
  logic  cmdState;

  assign cmdState  = (stateQ == S_START) || (stateQ == S_ADDR) || (stateQ == S_WR) ||
                     (stateQ == S_RD) || (stateQ == S_STOP);
  assign engGo     = cmdState && !issuedQ;
  assign engAckOut = !(cntOne && !reload);
  assign selAddr   = (stateQ == S_ADDR);
  assign wantTx    = (stateQ == S_CHECK) && !cntZero && !readDir;
  assign active    = (stateQ != S_IDLE);

  always_comb begin
    case (stateQ)
      S_START:      engCmd = ENG_START;
      S_ADDR, S_WR: engCmd = ENG_WRITE;
      S_RD:         engCmd = ENG_READ;
      default:      engCmd = ENG_STOP;
    endcase
  end

  always_comb begin
    strb       = '0;
    stateD     = stateQ;
    strb.txPop = engGo && (stateQ == S_WR);
    case (stateQ)
      S_IDLE: begin
        if (cfgWr) begin
          strb.loadAll  = 1'b1;
          strb.startSet = cfgStart;
        end else if (startPend && !lineBusy) begin
          stateD = S_START;
        end
      end
      S_START: if (engDone) stateD = S_ADDR;
      S_ADDR: begin
        if (engDone) begin
          strb.startClr = 1'b1;
          if (!engAckIn) begin
            strb.setNack = 1'b1;
            stateD = autoEnd ? S_STOP : S_HOLD;
          end else begin
            stateD = S_CHECK;
          end
        end
      end
      S_CHECK: begin
        if (cntZero) begin
          if (reload) begin
            strb.setTcr = 1'b1;
            stateD = S_PAUSE;
          end else if (autoEnd) begin
            stateD = S_STOP;
          end else begin
            strb.setTc = 1'b1;
            stateD = S_HOLD;
          end
        end else if (readDir) begin
          if (!rxFull) stateD = S_RD;
        end else if (txFull) begin
          stateD = S_WR;
        end
      end
      S_WR: begin
        if (engDone) begin
          if (!engAckIn) begin
            strb.setNack = 1'b1;
            stateD = autoEnd ? S_STOP : S_HOLD;
          end else begin
            strb.decCnt = 1'b1;
            stateD = S_CHECK;
          end
        end
      end
      S_RD: begin
        if (engDone) begin
          strb.rxPush = 1'b1;
          strb.decCnt = 1'b1;
          stateD = S_CHECK;
        end
      end
      S_PAUSE: begin
        if (cfgWr) begin
          strb.loadCnt = 1'b1;
          strb.clrDone = 1'b1;
          stateD = S_CHECK;
        end
      end
      S_HOLD: begin
        if (cfgWr) begin
          strb.clrDone = 1'b1;
          if (cfgStop) begin
            stateD = S_STOP;
          end else begin
            strb.loadAll = 1'b1;
            if (cfgStart) begin
              strb.startSet = 1'b1;
              stateD = S_START;
            end
          end
        end
      end
      S_STOP: if (engDone) stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
    if (engArlo && (stateQ != S_IDLE)) begin
      stateD = S_IDLE;
      strb.startClr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      issuedQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (engArlo || engDone) issuedQ <= 1'b0;
      else if (engGo)         issuedQ <= 1'b1;
    end
  end

endmodule

// File: rtl/i2c_xfer_dp.sv
module i2c_xfer_dp
  import i2c_xfer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrbT          strb,
  input  logic [6:0]       cfgAddr,
  input  logic             cfgRead,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgReload,
  input  logic             cfgAutoEnd,
  input  logic             txWr,
  input  logic [7:0]       txData,
  input  logic             txFlush,
  input  logic             rxRd,
  input  logic [NUM_ERR-1:0] clrFlags,
  input  logic [7:0]       engRxByte,
  input  logic             engArlo,
  input  logic             engBerr,
  output logic [7:0]       addrByte,
  output logic [7:0]       txBuf,
  output logic             txFull,
  output logic [7:0]       rxBuf,
  output logic             rxFull,
  output logic             cntZero,
  output logic             cntOne,
  output logic             readDir,
  output logic             reload,
  output logic             autoEnd,
  output logic             startPend,
  output logic             tcFlag,
  output logic             tcrFlag,
  output logic [NUM_ERR-1:0] errFlags
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [6:0]       addrQ;
  logic [CNT_W-1:0] cntQ;
  logic [NUM_ERR-1:0] errSet;

  assign addrByte = {addrQ, readDir};
  assign cntZero  = (cntQ == '0);
  assign cntOne   = (cntQ == CNT_ONE);
  assign errSet   = {engBerr, engArlo, strb.setNack};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; readDir <= 1'b0; cntQ <= '0; reload <= 1'b0; autoEnd <= 1'b0;
      txBuf <= '0; txFull <= 1'b0; rxBuf <= '0; rxFull <= 1'b0;
      startPend <= 1'b0; tcFlag <= 1'b0; tcrFlag <= 1'b0;
    end else begin
      if (strb.loadAll) begin
        addrQ   <= cfgAddr;
        readDir <= cfgRead;
      end
      if (strb.loadAll || strb.loadCnt) begin
        cntQ    <= cfgCount;
        reload  <= cfgReload;
        autoEnd <= cfgAutoEnd;
      end else if (strb.decCnt) begin
        cntQ <= cntQ - CNT_ONE;
      end
      if (strb.txPop || txFlush) txFull <= 1'b0;
      if (txWr) begin
        txFull <= 1'b1;
        txBuf  <= txData;
      end
      if (rxRd) rxFull <= 1'b0;
      if (strb.rxPush) begin
        rxFull <= 1'b1;
        rxBuf  <= engRxByte;
      end
      if (strb.startClr || engArlo) startPend <= 1'b0;
      else if (strb.startSet)       startPend <= 1'b1;
      if (strb.loadAll || strb.loadCnt || strb.clrDone) begin
        tcFlag  <= 1'b0;
        tcrFlag <= 1'b0;
      end
      if (strb.setTc)  tcFlag  <= 1'b1;
      if (strb.setTcr) tcrFlag <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_err
    logic flagQ;
    always_ff @(posedge clk) begin
      if (!rstN)            flagQ <= 1'b0;
      else if (errSet[g])   flagQ <= 1'b1;
      else if (clrFlags[g]) flagQ <= 1'b0;
    end
    assign errFlags[g] = flagQ;
  end

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_xfer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [6:0]       cfgAddr,
  input  logic             cfgRead,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             cfgReload,
  input  logic             cfgAutoEnd,
  input  logic             cfgStart,
  input  logic             cfgStop,
  input  logic             txWr,
  input  logic [7:0]       txData,
  input  logic             txFlush,
  input  logic             rxRd,
  input  logic [2:0]       clrFlags,
  input  logic             irqEn,
  output logic             startPend,
  output logic             busBusy,
  output logic             txEmpty,
  output logic             txReq,
  output logic             rxFull,
  output logic [7:0]       rxData,
  output logic             xferDone,
  output logic             xferReload,
  output logic             nackFlag,
  output logic             arloFlag,
  output logic             berrFlag,
  output logic             irq,
  output logic             engGo,
  output logic [1:0]       engCmd,
  output logic [7:0]       engTxByte,
  output logic             engAckOut,
  input  logic             engDone,
  input  logic             engAckIn,
  input  logic [7:0]       engRxByte,
  input  logic             engArlo,
  input  logic             engBerr,
  input  logic             lineBusy
);

  seqStrbT strb;
  engCmdT  cmdInt;
  logic    cntZero, cntOne, txFull, readDir, reload, autoEnd;
  logic    selAddr, wantTx, active;
  logic [7:0] addrByte, txBuf;
  logic [NUM_ERR-1:0] errFlags;

  i2c_xfer_ctrl u_ctrl (
    .clk, .rstN, .cfgWr, .cfgStart, .cfgStop, .engDone, .engAckIn, .engArlo,
    .lineBusy, .cntZero, .cntOne, .txFull, .rxFull, .readDir, .reload, .autoEnd,
    .startPend, .strb, .engGo, .engCmd(cmdInt), .engAckOut, .selAddr, .wantTx, .active
  );

  i2c_xfer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .strb, .cfgAddr, .cfgRead, .cfgCount, .cfgReload, .cfgAutoEnd,
    .txWr, .txData, .txFlush, .rxRd, .clrFlags, .engRxByte, .engArlo, .engBerr,
    .addrByte, .txBuf, .txFull, .rxBuf(rxData), .rxFull, .cntZero, .cntOne,
    .readDir, .reload, .autoEnd, .startPend, .tcFlag(xferDone), .tcrFlag(xferReload),
    .errFlags
  );

  assign engCmd    = cmdInt;
  assign engTxByte = selAddr ? addrByte : txBuf;
  assign busBusy   = lineBusy || active;
  assign txEmpty   = !txFull;
  assign txReq     = txEmpty && wantTx;
  assign nackFlag  = errFlags[0];
  assign arloFlag  = errFlags[1];
  assign berrFlag  = errFlags[2];
  assign irq       = irqEn && (xferDone || xferReload);

endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWr,
  input logic       xferDone,
  input logic       xferReload,
  input logic       rxFull,
  input logic       engGo,
  input logic [1:0] engCmd,
  input logic       engDone,
  input logic       engArlo
);

  logic pendQ;
  always_ff @(posedge clk) begin
    if (!rstN)                  pendQ <= 1'b0;
    else if (engDone || engArlo) pendQ <= 1'b0;
    else if (engGo)             pendQ <= 1'b1;
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    xferDone && !cfgWr |=> xferDone); // R6
  AST_RELOAD_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    xferReload && !cfgWr |=> xferReload); // R5
  AST_COMPLETE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xferDone, xferReload})); // R4
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    engGo |-> !pendQ); // R2
  AST_RX_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    engGo && (engCmd == 2'd2) |-> !rxFull); // R9
  AST_ARLO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    engArlo |=> !engGo); // R11

endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk chk_i (.*);

// File: tb/i2c_xfer_seq_tb_top.sv
module i2c_xfer_seq_tb_top;
  import i2c_xfer_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int EV_START = 'h100, EV_STOP = 'h200, EV_RACK = 'h800, EV_RNACK = 'hC00;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWr = 0, cfgRead = 0, cfgReload = 0, cfgAutoEnd = 0, cfgStart = 0, cfgStop = 0;
  logic [6:0] cfgAddr = '0;
  logic [7:0] cfgCount = '0;
  logic txWr = 0, txFlush = 0, rxRd = 0, irqEn = 0;
  logic [7:0] txData = '0;
  logic [2:0] clrFlags = '0;
  logic startPend, busBusy, txEmpty, txReq, rxFull, xferDone, xferReload;
  logic nackFlag, arloFlag, berrFlag, irq, engGo, engAckOut;
  logic [1:0] engCmd;
  logic [7:0] rxData, engTxByte;
  logic engDone = 0, engAckIn = 1, engArlo = 0, engBerr = 0, lineBusy = 0;
  logic [7:0] engRxByte = '0;

  int total = 0, bad = 0;
  int wireQ[$];
  int expQ[$];
  int wireMark = 0;
  bit nackAddr = 0;
  int nackDataAt = -1, arloAt = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_xfer_seq dut_i (.*);

  // Bus engine and register reference model
  int timer = 0, dataIdx = 0, rdIdx = 0;
  bit firstByte = 0, mTx = 0, mRx = 0;
  logic [1:0] curCmd = 2'd0;
  logic [7:0] curByte = '0;
  logic curAck = 1'b0;

  always @(posedge clk) begin
    engDone <= 1'b0;
    engArlo <= 1'b0;
    if (!rstN) begin
      timer = 0; mTx = 0; mRx = 0; firstByte = 0; dataIdx = 0; rdIdx = 0;
    end else begin
      if (rxRd) mRx = 0;
      if (engDone && curCmd == ENG_READ) mRx = 1;
      if ((engGo && engCmd == ENG_WRITE && !firstByte) || txFlush) mTx = 0;
      if (txWr) mTx = 1;
      if (engGo) begin
        curCmd = engCmd; curByte = engTxByte; curAck = engAckOut; timer = LAT;
      end else if (timer > 0) begin
        timer--;
        if (timer == 0) begin
          case (curCmd)
            ENG_START: begin
              wireQ.push_back(EV_START); firstByte = 1; rdIdx = 0; dataIdx = 0;
              engAckIn <= 1'b1; engDone <= 1'b1;
            end
            ENG_WRITE: begin
              if (!firstByte && dataIdx == arloAt) begin
                engArlo <= 1'b1; dataIdx++;
              end else begin
                wireQ.push_back(int'(curByte));
                engAckIn <= firstByte ? !nackAddr : (dataIdx != nackDataAt);
                if (!firstByte) dataIdx++;
                engDone <= 1'b1;
              end
              firstByte = 0;
            end
            ENG_READ: begin
              wireQ.push_back(curAck ? EV_RACK : EV_RNACK);
              engRxByte <= 8'hA0 + 8'(rdIdx); rdIdx++;
              engDone <= 1'b1;
            end
            default: begin
              wireQ.push_back(EV_STOP); engDone <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // Per-clock comparison against the reference register model (R2, R9)
  always @(negedge clk) begin
    if (rstN) begin
      total++;
      if (txEmpty !== !mTx) begin
        bad++; $display("FAIL R2 txEmpty act=%0d exp=%0d at %0t", txEmpty, !mTx, $time);
      end
      total++;
      if (rxFull !== mRx) begin
        bad++; $display("FAIL R9 rxFull act=%0d exp=%0d at %0t", rxFull, mRx, $time);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cmpWire(string tag);
    chk({tag, " wire length"}, wireQ.size() - wireMark, expQ.size());
    foreach (expQ[i])
      if (wireMark + i < wireQ.size()) chk({tag, " wire event"}, wireQ[wireMark + i], expQ[i]);
  endtask

  task automatic cfg(input logic [6:0] a, input logic rd, input logic [7:0] n,
                     input logic rl, input logic ae, input logic st, input logic sp);
    @(negedge clk);
    cfgAddr = a; cfgRead = rd; cfgCount = n; cfgReload = rl; cfgAutoEnd = ae;
    cfgStart = st; cfgStop = sp; cfgWr = 1;
    @(negedge clk);
    cfgWr = 0; cfgStart = 0; cfgStop = 0;
  endtask

  task automatic pulseTx(input logic [7:0] d);
    txData = d; txWr = 1;
    @(negedge clk);
    txWr = 0;
  endtask

  task automatic feed(int n, logic [7:0] base);
    for (int k = 0; k < n; k++) begin
      while (!txEmpty) @(negedge clk);
      pulseTx(base + 8'(k));
    end
  endtask

  task automatic readBytes(int n, int first);
    for (int k = 0; k < n; k++) begin
      while (!rxFull) @(negedge clk);
      chk("R9 rxData", rxData, 'hA0 + first + k);
      rxRd = 1;
      @(negedge clk);
      rxRd = 0;
    end
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busBusy) @(negedge clk);
  endtask

  task automatic clrPulse(input logic [2:0] m);
    clrFlags = m;
    @(negedge clk);
    clrFlags = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    chk("reset busBusy", busBusy, 0);
    chk("reset R13 txEmpty", txEmpty, 1);
    chk("reset R9 rxFull", rxFull, 0);
    chk("reset R7 irq", irq, 0);
    chk("reset R8 startPend", startPend, 0);
    chk("reset R6 xferDone", xferDone, 0);

    // write, auto end
    irqEn = 1;
    wireMark = wireQ.size();
    cfg(7'h3A, 0, 3, 0, 1, 1, 0);
    chk("R8 startPend after request", startPend, 1);
    feed(3, 8'h11);
    waitIdle();
    expQ = {EV_START, 'h74, 'h11, 'h12, 'h13, EV_STOP};
    cmpWire("R1 R3 write autoend");
    chk("R3 no xferDone", xferDone, 0);
    chk("R8 startPend cleared", startPend, 0);

    // data stall until tx loaded
    wireMark = wireQ.size();
    cfg(7'h05, 0, 1, 0, 1, 1, 0);
    repeat (20) @(negedge clk);
    expQ = {EV_START, 'h0A};
    cmpWire("R2 stall");
    chk("R2 txReq while waiting", txReq, 1);
    pulseTx(8'h61);
    waitIdle();
    expQ = {EV_START, 'h0A, 'h61, EV_STOP};
    cmpWire("R2 after load");

    // software end, then repeated start read
    wireMark = wireQ.size();
    cfg(7'h55, 0, 2, 0, 0, 1, 0);
    feed(2, 8'h21);
    while (!xferDone) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R7 irq on done", irq, 1);
    chk("R4 bus held", busBusy, 1);
    clrPulse(3'b111);
    repeat (3) @(negedge clk);
    chk("R6 done kept after clear", xferDone, 1);
    expQ = {EV_START, 'hAA, 'h21, 'h22};
    cmpWire("R4 no stop while held");
    irqEn = 0;
    @(negedge clk);
    chk("R7 irq masked", irq, 0);
    irqEn = 1;
    cfg(7'h55, 1, 2, 0, 1, 1, 0);
    chk("R6 done cleared by cfg write", xferDone, 0);
    readBytes(2, 0);
    waitIdle();
    expQ = {EV_START, 'hAA, 'h21, 'h22, EV_START, 'hAB, EV_RACK, EV_RNACK, EV_STOP};
    cmpWire("R4 R9 repeated start read");

    // reload chaining
    wireMark = wireQ.size();
    cfg(7'h10, 1, 2, 1, 0, 1, 0);
    readBytes(2, 0);
    while (!xferReload) @(negedge clk);
    chk("R5 not done", xferDone, 0);
    chk("R7 irq on reload", irq, 1);
    clrPulse(3'b111);
    @(negedge clk);
    chk("R6 reload kept after clear", xferReload, 1);
    cfg(7'h10, 1, 1, 0, 1, 0, 0);
    chk("R5 reload cleared by count", xferReload, 0);
    readBytes(1, 2);
    waitIdle();
    expQ = {EV_START, 'h21, EV_RACK, EV_RACK, EV_RNACK, EV_STOP};
    cmpWire("R5 R9 reload continue");

    // address nack, auto end
    nackAddr = 1;
    wireMark = wireQ.size();
    cfg(7'h05, 0, 1, 0, 1, 1, 0);
    waitIdle();
    nackAddr = 0;
    chk("R10 nack flag", nackFlag, 1);
    expQ = {EV_START, 'h0A, EV_STOP};
    cmpWire("R10 address nack");
    clrPulse(3'b001);
    chk("R10 nack cleared", nackFlag, 0);

    // data nack, software end
    nackDataAt = 0;
    wireMark = wireQ.size();
    pulseTx(8'h31);
    cfg(7'h05, 0, 2, 0, 0, 1, 0);
    while (!nackFlag) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R10 held after nack", busBusy, 1);
    chk("R10 no done after nack", xferDone, 0);
    expQ = {EV_START, 'h0A, 'h31};
    cmpWire("R10 hold no stop");
    cfg(7'h05, 0, 0, 0, 0, 0, 1);
    waitIdle();
    expQ = {EV_START, 'h0A, 'h31, EV_STOP};
    cmpWire("R10 stop on request");
    clrPulse(3'b001);
    nackDataAt = -1;

    // arbitration loss
    arloAt = 1;
    wireMark = wireQ.size();
    cfg(7'h05, 0, 3, 0, 1, 1, 0);
    feed(2, 8'h41);
    waitIdle();
    arloAt = -1;
    chk("R11 arlo flag", arloFlag, 1);
    chk("R11 startPend cleared", startPend, 0);
    expQ = {EV_START, 'h0A, 'h41};
    cmpWire("R11 no stop");
    clrPulse(3'b010);
    chk("R11 arlo cleared", arloFlag, 0);

    // flush
    pulseTx(8'h99);
    chk("R13 loaded", txEmpty, 0);
    txFlush = 1;
    @(negedge clk);
    txFlush = 0;
    chk("R13 flushed", txEmpty, 1);

    // line busy blocks start
    lineBusy = 1;
    wireMark = wireQ.size();
    pulseTx(8'h51);
    cfg(7'h05, 0, 1, 0, 1, 1, 0);
    repeat (10) @(negedge clk);
    chk("R8 no start while line busy", wireQ.size() - wireMark, 0);
    chk("R8 startPend held", startPend, 1);
    lineBusy = 0;
    waitIdle();
    expQ = {EV_START, 'h0A, 'h51, EV_STOP};
    cmpWire("R8 start after release");

    // bus error
    engBerr = 1;
    @(negedge clk);
    engBerr = 0;
    chk("R12 berr set", berrFlag, 1);
    clrPulse(3'b100);
    chk("R12 berr cleared", berrFlag, 0);

    summary();
    $finish;
  end

endmodule